// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Error Status

This block recovers asynchronous serial characters from a receive line. It samples the line on a 16x oversampling tick and confirms a start bit at its midpoint. It then collects 5 to 8 data bits, least significant bit first, followed by an optional parity bit and a stop bit. The framing settings are the same ones the companion transmitter uses: word length, parity enable, even or odd parity, and stick parity.

Each recovered character goes into a small receive queue. Four status bits are stored with it, so software learns which character was damaged and not only that some character was. The queue shows its head word at the read port and drops it on a read strobe. Empty and full flags report the queue level. A loopback select takes the serial input from the transmitter's output instead of the external pin, so the framing path can be tested with no wiring.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset `rx_empty` is 1 and `rx_full` is 0.
- R2: A falling edge on the selected line starts a character only if the line is still low at the 8th tick after the edge. A low pulse shorter than that stores nothing. Each later bit is sampled 16 ticks after the previous sample.
- R3: The word length code `wlen` selects the data bit count: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Data arrives least significant bit first. It appears in `rd_data[7:0]`, and data bits at or above the word length read as zero.
- R4: With `par_en` high, one parity bit follows the data. The expected parity bit depends on the settings:
  - With `par_stick` low, it is the XOR of the data bits when `par_even` is 1, and the inverse of that XOR when `par_even` is 0.
  - With `par_stick` high, it is 0 when `par_even` is 1 and 1 when `par_even` is 0.
  A mismatch sets `rd_data[9]`. With `par_en` low there is no parity bit and `rd_data[9]` is 0.
- R5: A stop bit sampled low sets the framing flag `rd_data[8]`.
- R6: If every data bit, the parity bit (when enabled) and the stop bit are all sampled low, the break flag `rd_data[10]` is set, together with `rd_data[8]`. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: A character that completes while the queue is full is discarded. The overrun flag `rd_data[11]` is then set on the next character that is stored.
- R8: `rx_empty` is 1 exactly when the queue holds no character. `rx_full` is 1 exactly when it holds `DEPTH` characters.
- R9: Characters are received only while both `en_global` and `en_rx` are high. Otherwise the receiver stays idle and stores nothing.
- R10: With `loop_en` high the receiver takes its input from `txd_loop` and ignores `rxd`.
- R11: `rd_data` shows the oldest stored character. A one-cycle `rd` pulse while not empty removes it, and the queue keeps arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | External serial input, idle high |
| txd_loop | input | 1 | Transmitter output, used in loopback |
| en_global | input | 1 | Global enable |
| en_rx | input | 1 | Receive enable |
| loop_en | input | 1 | Loopback select |
| wlen | input | 2 | Word length code (5 plus code) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| rd | input | 1 | Remove head character |
| rd_data | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue full |

## Verification
The bench aims at the corner cases where a receiver's sample timing or parity polarity is easy to get wrong:
- A short low glitch. A receiver that does not recheck the line at mid-bit would store a spurious character.
- Both stick parity polarities and odd parity on an all-zero character. A swapped polarity would raise a parity error on a clean frame.
- A short word with high bits driven on the line. A receiver that does not clear its unused upper bits would show stale ones.

On overrun, it checks two things. The extra character must not displace a stored one. The flag must land on the next character stored, not on a queued one, and not be lost. It also checks that a break raises both the break and framing flags, that reception stays off unless both enables are set, and that loopback ignores a pin that is held low.

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rxd,
  input  logic        txd_loop,
  input  logic        en_global,
  input  logic        en_rx,
  input  logic        loop_en,
  input  logic [1:0]  wlen,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        rd,
  output logic [11:0] rd_data,
  output logic        rx_empty,
  output logic        rx_full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_t;

  st_t           st;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shf;
  logic          pbit, allz, ovr_pend;
  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   level;

  wire ln      = sync_q[1];
  wire run     = en_global & en_rx;
  wire mid     = (cnt == CW'(HALF - 1));
  wire last    = (cnt == CW'(OSR - 1));
  wire [2:0] lastbit = 3'd4 + {1'b0, wlen};
  wire exp_par = par_stick ? ~par_even : (par_even ? ^shf : ~^shf);
  wire pe      = par_en & (pbit != exp_par);
  wire push    = tick16 & run & (st == S_STOP) & last;
  wire wr      = push & ~rx_full;
  wire pop     = rd & ~rx_empty;
  wire [11:0] word = {ovr_pend, ~ln & allz, pe, ~ln, shf};

  assign rx_empty = (level == '0);
  assign rx_full  = (level == (AW+1)'(DEPTH));
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], loop_en ? txd_loop : rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; shf <= '0; pbit <= 1'b0; allz <= 1'b0;
    end else if (!run) begin
      st <= S_IDLE;
    end else if (tick16) begin
      case (st)
        S_IDLE: if (!ln) begin st <= S_START; cnt <= '0; end
        S_START:
          if (mid) begin
            if (ln) st <= S_IDLE;
            else begin st <= S_DATA; cnt <= '0; bitn <= '0; shf <= '0; allz <= 1'b1; end
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (last) begin
            cnt <= '0;
            shf[bitn] <= ln;
            allz <= allz & ~ln;
            if (bitn == lastbit) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (last) begin
            cnt <= '0; pbit <= ln; allz <= allz & ~ln; st <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (last) st <= ln ? S_IDLE : S_WAITHI;
          else cnt <= cnt + 1'b1;
        default: if (ln) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0; ovr_pend <= 1'b0;
    end else begin
      if (push && rx_full) ovr_pend <= 1'b1;
      else if (wr)         ovr_pend <= 1'b0;
      if (wr)  wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level <= level + (AW+1)'(wr) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= word;
endmodule

module uart_rx_stat_chk #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en_global,
  input logic        en_rx,
  input logic        rd,
  input logic [11:0] rd_data,
  input logic        rx_empty,
  input logic        rx_full
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full)); // R8
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en_global && en_rx) && rx_empty) |=> rx_empty); // R9
  AST_BREAK_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_empty && rd_data[10]) |-> rd_data[8]); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd) |=> rx_full); // R7
  AST_POP_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rd) |=> !rx_full); // R11
endmodule

bind uart_rx_stat uart_rx_stat_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_rx(en_rx), .rd(rd),
  .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full));

// File: tb/test_uart_rx_stat.sv
module test_uart_rx_stat;
  localparam int DEPTH = 4;
  localparam int BITCLK = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic rxd = 1'b1, txd_loop = 1'b1, en_global = 1'b1, en_rx = 1'b1, loop_en = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, rd = 1'b0;
  logic [11:0] rd_data;
  logic rx_empty, rx_full;
  logic [1:0] tdiv = '0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_rx_stat #(.DEPTH(DEPTH)) i_uart_rx_stat (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .txd_loop(txd_loop),
    .en_global(en_global), .en_rx(en_rx), .loop_en(loop_en), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .rd(rd),
    .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full));

  // {wlen[1:0], pen, even, stick, badpar, stop, data[7:0]}
  localparam logic [14:0] VEC [9] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h35},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h2A},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h81},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h7E},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}
  };

  function automatic logic [7:0] dmask(input logic [1:0] w);
    return 8'hFF >> (3 - w);
  endfunction

  function automatic logic sent_par(input logic [14:0] v);
    logic [7:0] m = v[7:0] & dmask(v[14:13]);
    logic cp = v[10] ? ~v[11] : (v[11] ? ^m : ~^m);
    return cp ^ v[9];
  endfunction

  function automatic logic [11:0] expect_word(input logic [14:0] v, input logic ovr);
    logic [7:0] m = v[7:0] & dmask(v[14:13]);
    logic fe = ~v[8];
    logic pe = v[12] & v[9];
    logic brk = fe && (m == 8'h00) && (!v[12] || !sent_par(v));
    return {ovr, brk, pe, fe, m};
  endfunction

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic to_loop, input logic b);
    @(negedge clk);
    if (to_loop) txd_loop = b; else rxd = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic send(input logic to_loop, input logic [14:0] v);
    wlen = v[14:13]; par_en = v[12]; par_even = v[11]; par_stick = v[10];
    drive(to_loop, 1'b0);
    for (int i = 0; i < 5 + int'(v[14:13]); i++) drive(to_loop, v[i]);
    if (v[12]) drive(to_loop, sent_par(v));
    drive(to_loop, v[8]);
    drive(to_loop, 1'b1);
    drive(to_loop, 1'b1);
  endtask

  task automatic pop();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty after reset", 12'(rx_empty), 12'd1);
    chk("R1 full after reset", 12'(rx_full), 12'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4 R5 R6 R11: table walk
    foreach (VEC[k]) begin
      send(1'b0, VEC[k]);
      chk("R8 not empty after frame", 12'(rx_empty), 12'd0);
      chk("R3/R4/R5/R6 word", rd_data, expect_word(VEC[k], 1'b0));
      pop();
      chk("R11 empty after pop", 12'(rx_empty), 12'd1);
    end

    // R2: short glitch
    wlen = 2'd3; par_en = 1'b0;
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    chk("R2 glitch stores nothing", 12'(rx_empty), 12'd1);

    // R9: enables
    en_rx = 1'b0;
    send(1'b0, {2'd3, 5'b00001, 8'h11});
    chk("R9 en_rx low stores nothing", 12'(rx_empty), 12'd1);
    en_rx = 1'b1; en_global = 1'b0;
    send(1'b0, {2'd3, 5'b00001, 8'h22});
    chk("R9 en_global low stores nothing", 12'(rx_empty), 12'd1);
    en_global = 1'b1;

    // R10: loopback with rxd held low
    loop_en = 1'b1;
    @(negedge clk); rxd = 1'b0;
    send(1'b1, {2'd3, 5'b00001, 8'hC3});
    chk("R10 loopback word", rd_data, 12'h0C3);
    pop();
    chk("R10 rxd ignored", 12'(rx_empty), 12'd1);
    rxd = 1'b1; repeat (4) @(negedge clk); loop_en = 1'b0;

    // R7 R8 R11: fill, overrun, order
    for (int i = 0; i <= DEPTH; i++) send(1'b0, {2'd3, 5'b00001, 8'(8'h40 + i)});
    chk("R8 full at DEPTH", 12'(rx_full), 12'd1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R11/R7 order, no overrun on queued", rd_data, 12'(8'h40 + i));
      pop();
    end
    chk("R7 extra char discarded", 12'(rx_empty), 12'd1);
    send(1'b0, {2'd3, 5'b00001, 8'h5A});
    chk("R7 overrun on next stored", rd_data, 12'h85A);
    pop();
    send(1'b0, {2'd3, 5'b00001, 8'h5B});
    chk("R7 overrun cleared after", rd_data, 12'h05B);
    pop();

    finish_run();
  end
endmodule